// File: doc/BRIEF.md
# Dual-mode serial transmitter

This block turns 8-bit words into a serial stream in one of two formats. A CPU-visible mode register chooses the format. In asynchronous mode each character is framed by a start bit and a stop bit, with a 7-bit or 8-bit payload and an optional even or odd parity bit. In clock-synchronous mode the block shifts eight bits against a serial clock that it drives itself. In that mode the length and parity settings are ignored.

Words enter through a one-entry holding register with a valid/ready handshake. An external baud generator supplies a single-cycle tick that paces every bit. The engine copies the mode settings when it loads a word, so a register write made in the middle of a character applies from the next character. If a word is waiting when the last bit of a character ends, the next character follows with no idle gap.

Top module: `sertx_top`

## Requirements
- R1: The mode register is 8 bits wide and resets to 0x00. A write with `cfg_we` shows on `cfg_rdata` in the next cycle. Bit 7 selects synchronous mode (1) or asynchronous mode (0). Bit 6 selects 7 data bits (1) or 8 (0). Bit 5 enables parity. Bit 4 selects odd parity (1) or even parity (0). Bits 3:0 are stored and have no effect.
- R2: `tx_ready` and `tx_empty` are both high exactly when the holding register is free. A word is accepted on a cycle with `tx_valid` and `tx_ready` both high, and both flags are low in the cycle after acceptance.
- R3: A waiting word is moved into the engine only on a cycle with `baud_tick` high, and only when the engine is idle or is ending its last bit. In the cycle after that move, `busy` is high, `tx_empty` is high and the first bit is on `ser_out`.
- R4: An asynchronous frame is sent in this order: a start bit (0), the data bits LSB first, the parity bit if enabled, and one stop bit (1). Each bit lasts from one tick to the next. `ser_clk` stays high for the whole frame.
- R5: With bit 6 set in asynchronous mode, only data bits 0 to 6 are sent, so data bit 7 has no effect on the line.
- R6: With bit 5 set in asynchronous mode, one parity bit follows the data. It makes the number of ones among the sent data bits plus the parity bit even when bit 4 is 0, and odd when bit 4 is 1.
- R7: In synchronous mode, exactly 8 data bits are sent LSB first, with no start, parity or stop bit, whatever bits 6 and 5 hold. Each bit spans two ticks. `ser_clk` falls at the first tick, at the same edge on which `ser_out` changes, and rises at the second tick.
- R8: `busy` stays high from the load until the tick that ends the last bit. After that tick `ser_out` and `ser_clk` are both high.
- R9: A mode register write made while a character is being sent does not change that character's format.
- R10: If a word is waiting at the tick that ends a character, the next character starts on that same tick and `busy` does not drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write value |
| cfg_rdata | output | 8 | Mode register read value |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 8 | Transmit word |
| tx_ready | output | 1 | Holding register can take a word |
| baud_tick | input | 1 | One-cycle bit-rate enable |
| ser_out | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial clock, synchronous mode only |
| busy | output | 1 | A character is being sent |
| tx_empty | output | 1 | Holding register is empty |

## Verification
The bench targets the cases where the format setting could leak into the wrong place:
- **7-bit payloads with bit 7 set.** A design that sent the MSB would stretch the frame by one bit.
- **Parity over 7 bits.** A design that computed parity over all 8 bits would send the wrong parity bit.
- **Synchronous mode with length and parity bits set.** A design that did not force 8 bits and no parity would send a 7-bit or 9-bit character.
- **A mode write in the middle of a character.** A design that read the live register instead of its copy would change the frame length part-way through.
- **Back-to-back loads.** A design that only loaded when idle would insert an idle bit between characters and let `busy` drop.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    parameter int DW = 8;
    localparam int FW = DW + 3;
    localparam int CW = $clog2(FW + 1);

    localparam int MB_SYNC  = 7;
    localparam int MB_SHORT = 6;
    localparam int MB_PAREN = 5;
    localparam int MB_ODD   = 4;

    typedef struct packed {
        logic sync;
        logic short_len;
        logic par_en;
        logic par_odd;
    } mode_t;

    typedef struct packed {
        logic [FW-1:0] bits;
        logic [CW-1:0] count;
    } frame_t;

    typedef struct packed {
        logic          busy;
        logic          sync;
        logic          sout;
        logic          sclk;
        logic [FW-2:0] sh;
        logic [CW-1:0] rem;
    } eng_t;

    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
    } hold_t;

    function automatic frame_t build_frame(mode_t m, logic [DW-1:0] d);
        frame_t        f;
        int            n;
        logic [DW-1:0] mask;
        logic          p;
        f.bits = '1;
        if (m.sync) begin
            f.bits[DW-1:0] = d;
            f.count = CW'(DW);
        end else begin
            n    = m.short_len ? DW - 1 : DW;
            mask = m.short_len ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};
            p    = m.par_odd ^ (^(d & mask));
            f.bits[0] = 1'b0;
            for (int i = 0; i < DW; i++) begin
                if (i < n) f.bits[1+i] = d[i];
            end
            if (m.par_en) f.bits[1+n] = p;
            f.count = CW'(2 + n + (m.par_en ? 1 : 0));
        end
        return f;
    endfunction
endpackage

// File: rtl/sertx_mode_reg.sv
module sertx_mode_reg
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output mode_t      mode
);
    logic [7:0] reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (we) reg_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign rdata          = reg_q;
    assign mode.sync      = reg_q[MB_SYNC];
    assign mode.short_len = reg_q[MB_SHORT];
    assign mode.par_en    = reg_q[MB_PAREN];
    assign mode.par_odd   = reg_q[MB_ODD];
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);
    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) hold_d.full = 1'b0;
        if (in_valid && !hold_q.full) begin
            hold_d.full = 1'b1;
            hold_d.data = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign in_ready = !hold_q.full;
    assign full     = hold_q.full;
    assign data     = hold_q.data;
endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
    import sertx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  mode_t         mode,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    output logic          take,
    output logic          sout,
    output logic          sclk,
    output logic          busy,
    output logic          sync_active
);
    eng_t   eng_d, eng_q;
    frame_t fr;
    logic   last;

    always_comb begin
        eng_d = eng_q;
        take  = 1'b0;
        fr    = build_frame(mode, hold_data);
        last  = (eng_q.rem == '0) && (!eng_q.sync || eng_q.sclk);
        if (tick && eng_q.busy) begin
            if (eng_q.sync && !eng_q.sclk) begin
                eng_d.sclk = 1'b1;
            end else if (last) begin
                eng_d.busy = 1'b0;
                eng_d.sout = 1'b1;
                eng_d.sclk = 1'b1;
            end else begin
                eng_d.sout = eng_q.sh[0];
                eng_d.sh   = {1'b1, eng_q.sh[FW-2:1]};
                eng_d.rem  = eng_q.rem - 1'b1;
                if (eng_q.sync) eng_d.sclk = 1'b0;
            end
        end
        if (tick && hold_full && (!eng_q.busy || last)) begin
            take       = 1'b1;
            eng_d.busy = 1'b1;
            eng_d.sync = mode.sync;
            eng_d.sout = fr.bits[0];
            eng_d.sh   = fr.bits[FW-1:1];
            eng_d.rem  = fr.count - 1'b1;
            eng_d.sclk = !mode.sync;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q      <= '0;
            eng_q.sout <= 1'b1;
            eng_q.sclk <= 1'b1;
            eng_q.sh   <= '1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sout        = eng_q.sout;
    assign sclk        = eng_q.sclk;
    assign busy        = eng_q.busy;
    assign sync_active = eng_q.sync;
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    input  logic       baud_tick,
    output logic       ser_out,
    output logic       ser_clk,
    output logic       busy,
    output logic       tx_empty
);
    mode_t         mode;
    logic          hold_full;
    logic [DW-1:0] hold_data;
    logic          take;
    logic          eng_sync;

    sertx_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .mode  (mode)
    );

    sertx_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .in_ready (tx_ready),
        .take     (take),
        .full     (hold_full),
        .data     (hold_data)
    );

    sertx_engine u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (baud_tick),
        .mode        (mode),
        .hold_full   (hold_full),
        .hold_data   (hold_data),
        .take        (take),
        .sout        (ser_out),
        .sclk        (ser_clk),
        .busy        (busy),
        .sync_active (eng_sync)
    );

    assign tx_empty = !hold_full;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_empty,
    input logic       baud_tick,
    input logic       ser_out,
    input logic       ser_clk,
    input logic       busy,
    input logic       eng_sync
);
    AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == $past(cfg_wdata)); // R1

    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_empty && !tx_ready); // R2

    AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> busy && $past(baud_tick)); // R3

    AST_ASYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && !eng_sync |-> !ser_out); // R4

    AST_ASYNC_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !eng_sync |-> ser_clk); // R4

    AST_SYNC_DATA_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && eng_sync && !$stable(ser_out) |-> $fell(ser_clk)); // R7

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ser_out && ser_clk); // R8

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(eng_sync)); // R9
endmodule

bind sertx_top sertx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_empty  (tx_empty),
    .baud_tick (baud_tick),
    .ser_out   (ser_out),
    .ser_clk   (ser_clk),
    .busy      (busy),
    .eng_sync  (eng_sync)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready;
    logic       baud_tick = 1'b0;
    logic       ser_out, ser_clk, busy, tx_empty;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    int         tick_cnt = 0;

    localparam logic [15:0] VECS [8] = '{
        16'h00A5, 16'h40C3, 16'h20B1, 16'h30B1,
        16'h607F, 16'h70FF, 16'h805A, 16'hE096
    };

    always #2 clk = ~clk;

    sertx_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .baud_tick(baud_tick), .ser_out(ser_out),
        .ser_clk(ser_clk), .busy(busy), .tx_empty(tx_empty)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            baud_tick <= (tick_cnt == 3);
            tick_cnt  <= (tick_cnt + 1) % 4;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] v);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1; tx_data = v;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic step(input bit wr, input logic [7:0] v);
        if (wr) begin cfg_we = 1'b1; cfg_wdata = v; end
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_frame(input string req, input logic [7:0] cfg, input logic [7:0] d,
                               input bit wait_rise, input bit mid, input logic [7:0] mid_v,
                               input bit expect_idle);
        logic [10:0] bits;
        int          n, cnt, ones;
        logic        p;
        if (wait_rise) begin
            for (int k = 0; k < 200 && !busy; k++) @(negedge clk);
            chk({req, " R3 busy at load"}, busy, 1'b1);
            chk({req, " R3 empty after load"}, tx_empty, 1'b1);
        end
        if (cfg[7]) begin
            for (int i = 0; i < 8; i++) begin
                chk({req, " R7 clk low"}, ser_clk, 1'b0);
                chk({req, " R7 data"}, ser_out, d[i]);
                step(mid && i == 0, mid_v);
                chk({req, " R7 clk high"}, ser_clk, 1'b1);
                chk({req, " R7 data held"}, ser_out, d[i]);
                step(1'b0, 8'h00);
            end
        end else begin
            n    = cfg[6] ? 7 : 8;
            ones = $countones(d & (cfg[6] ? 8'h7F : 8'hFF));
            p    = cfg[4] ? ~ones[0] : ones[0];
            bits = '1;
            bits[0] = 1'b0;
            for (int i = 0; i < n; i++) bits[1+i] = d[i];
            if (cfg[5]) bits[1+n] = p;
            cnt = 2 + n + (cfg[5] ? 1 : 0);
            for (int i = 0; i < cnt; i++) begin
                chk({req, " R4 bit"}, ser_out, bits[i]);
                chk({req, " R4 clk idle"}, ser_clk, 1'b1);
                chk({req, " busy in frame"}, busy, 1'b1);
                step(mid && i == 0, mid_v);
            end
        end
        if (expect_idle) begin
            chk({req, " R8 busy end"}, busy, 1'b0);
            chk({req, " R8 line high"}, ser_out, 1'b1);
            chk({req, " R8 clk high"}, ser_clk, 1'b1);
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset cfg", cfg_rdata, 8'h00);
        chk("R8 reset line", {ser_out, ser_clk, busy}, 3'b110);
        chk("R2 reset flags", {tx_empty, tx_ready}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        write_cfg(8'hF3);
        chk("R1 readback", cfg_rdata, 8'hF3);
        chk("R1 no start", busy, 1'b0);

        for (int v = 0; v < 8; v++) begin
            write_cfg(VECS[v][15:8]);
            chk("R1 cfg", cfg_rdata, VECS[v][15:8]);
            push(VECS[v][7:0]);
            chk("R2 full after accept", {tx_empty, tx_ready}, 2'b00);
            check_frame(VECS[v][15:8] == 8'h40 ? "R5" :
                        VECS[v][15:8] == 8'hE0 ? "R7" :
                        VECS[v][15:8][5] ? "R6" : "R4",
                        VECS[v][15:8], VECS[v][7:0], 1'b1, 1'b0, 8'h00, 1'b1);
        end

        // R5: MSB differs, line identical and frame length unchanged
        write_cfg(8'h40);
        push(8'h80);
        check_frame("R5 msb ignored", 8'h40, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1);

        // R9: switch to parity and to sync mid-frame
        write_cfg(8'h00);
        push(8'h3C);
        check_frame("R9 async held", 8'h00, 8'h3C, 1'b1, 1'b1, 8'hA0, 1'b1);
        chk("R9 new cfg visible", cfg_rdata, 8'hA0);
        push(8'h69);
        check_frame("R9 next uses new", 8'hA0, 8'h69, 1'b1, 1'b0, 8'h00, 1'b1);

        // R10: back-to-back async then sync
        write_cfg(8'h20);
        push(8'h11);
        for (int k = 0; k < 200 && !busy; k++) @(negedge clk);
        push(8'hEE);
        check_frame("R10 first", 8'h20, 8'h11, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R10 no gap", busy, 1'b1);
        check_frame("R10 second", 8'h20, 8'hEE, 1'b0, 1'b0, 8'h00, 1'b1);

        write_cfg(8'h80);
        push(8'hC1);
        for (int k = 0; k < 200 && !busy; k++) @(negedge clk);
        push(8'h3E);
        check_frame("R10 sync first", 8'h80, 8'hC1, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R10 sync no gap", busy, 1'b1);
        check_frame("R10 sync second", 8'h80, 8'h3E, 1'b0, 1'b0, 8'h00, 1'b1);

        report();
    end
endmodule